// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a single burst request into the column address for each beat of an SDRAM read or write burst. A request carries a starting column, a three-bit length code and an ordering bit. For the rest of the burst the block walks through the columns of an aligned block in sequential or interleaved order. Beats wrap inside that block and never cross into the next one. A full-page mode runs through every column of the page in sequential order and wraps at the page end. A terminate input can cut any burst short.

A memory controller uses the block beside its command sequencer. It pulses `start_i` together with the column that the READ or WRITE command carries. It then uses `col_o` for every cycle in which `valid_o` is high. `last_o` marks the final beat, so a following burst can be started in that same cycle with no idle cycle between the two.

Top module: `sdram_burst_addr_gen`

## Requirements
- R1: In the cycle after a synchronous reset, `valid_o` and `last_o` are both low.
- R2: The length code `len_code_i` selects the burst span: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives a full page of 2^COL_W beats. The reserved codes 4, 5 and 6 give a single beat. `valid_o` stays high on consecutive cycles for exactly that many beats, unless the burst is terminated.
- R3: When a start is accepted, beat 0 appears in the next cycle and its column equals the start column.
- R4: With `order_i` = 0 (sequential) and span L, the low log2(L) bits of beat i equal (start + i) mod L. The upper bits are those of the start column.
- R5: With `order_i` = 1 (interleaved) and span L, the low log2(L) bits of beat i equal start XOR i. The upper bits are those of the start column.
- R6: A full-page burst always uses sequential order, whatever the value of `order_i`.
- R7: In a full-page burst, beat i is at column (start + i) mod 2^COL_W, so the burst wraps from the last column of the page to column 0.
- R8: `last_o` is high only on the final beat of a burst. In the cycle after `last_o`, `valid_o` is low unless a new start was accepted.
- R9: When `term_i` is high in a cycle with `valid_o` high, `last_o` is high in that same cycle and the burst ends. When `valid_o` is low, `term_i` has no effect on the outputs.
- R10: A start request on a beat that is not the last is ignored, and the running burst continues unchanged. A start request on the last beat begins the new burst in the next cycle, with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Burst request |
| start_col_i | input | COL_W | Starting column of the requested burst |
| len_code_i | input | 3 | Burst span code |
| order_i | input | 1 | 0 = sequential, 1 = interleaved |
| term_i | input | 1 | End the running burst at the current beat |
| col_o | output | COL_W | Column for the current beat |
| valid_o | output | 1 | A beat is present on `col_o` |
| last_o | output | 1 | Current beat is the final one |

## Verification
The hardest situations to reach from the ports are those where requests overlap a running burst. These are a start that arrives on the last beat, a start that arrives mid-burst and must be ignored, and a terminate that arrives on a chosen beat, including beat 0 of a full-page burst. The stimulus reaches them by chaining bursts. Where the beat allows, it drives a stray start with a random column mid-burst. It also picks the terminate beat at random, and the directed cases add a full-page burst that crosses the page end and a 2^COL_W-beat burst with no terminate.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic [2:0] {
        SPAN_1    = 3'd0,
        SPAN_2    = 3'd1,
        SPAN_4    = 3'd2,
        SPAN_8    = 3'd3,
        SPAN_PAGE = 3'd4
    } span_e;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    typedef struct packed {
        span_e  span;
        order_e order;
    } burst_mode_t;

    // Length code to span; reserved codes fall back to a single beat.
    function automatic span_e code_to_span(input logic [2:0] code);
        case (code)
            3'd1:    return SPAN_2;
            3'd2:    return SPAN_4;
            3'd3:    return SPAN_8;
            3'd7:    return SPAN_PAGE;
            default: return SPAN_1;
        endcase
    endfunction

    // Number of low column bits the span occupies (page handled separately).
    function automatic int unsigned span_bits(input span_e s);
        case (s)
            SPAN_2:  return 1;
            SPAN_4:  return 2;
            SPAN_8:  return 3;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
    import burst_pkg::*;
(
    input  logic [2:0]  len_code_i,
    input  logic        order_i,
    output burst_mode_t mode_o
);
    span_e span_w;

    always_comb begin
        span_w       = code_to_span(len_code_i);
        mode_o.span  = span_w;
        // Page-long bursts only exist in sequential order (R6).
        mode_o.order = (span_w == SPAN_PAGE || !order_i) ? ORD_SEQ : ORD_ILV;
    end
endmodule

// File: rtl/burst_span_mask.sv
module burst_span_mask
    import burst_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  span_e              span_i,
    output logic [COL_W-1:0]   mask_o
);
    int unsigned nbits;

    always_comb nbits = span_bits(span_i);

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign mask_o[b] = (span_i == SPAN_PAGE) || (b < nbits);
    end
endmodule

// File: rtl/burst_beat_seq.sv
module burst_beat_seq
    import burst_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             term_i,
    input  logic [COL_W-1:0] start_col_i,
    input  burst_mode_t      mode_i,
    input  logic [COL_W-1:0] mask_i,
    output logic             valid_o,
    output logic             last_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] anchor_o,
    output logic [COL_W-1:0] mask_o,
    output order_e           order_o
);
    logic             valid_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] anchor_q;
    logic [COL_W-1:0] mask_q;
    order_e           order_q;
    logic             final_beat;
    logic             accept;

    always_comb begin
        // The beat index reaches the mask value on the final beat: span - 1.
        final_beat = valid_q && ((beat_q == mask_q) || term_i);
        accept     = start_i && (!valid_q || final_beat);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            beat_q   <= '0;
            anchor_q <= '0;
            mask_q   <= '0;
            order_q  <= ORD_SEQ;
        end else if (accept) begin
            valid_q  <= 1'b1;
            beat_q   <= '0;
            anchor_q <= start_col_i;
            mask_q   <= mask_i;
            order_q  <= mode_i.order;
        end else if (final_beat) begin
            valid_q  <= 1'b0;
        end else if (valid_q) begin
            beat_q   <= beat_q + COL_W'(1);
        end
    end

    assign valid_o  = valid_q;
    assign last_o   = final_beat;
    assign beat_o   = beat_q;
    assign anchor_o = anchor_q;
    assign mask_o   = mask_q;
    assign order_o  = order_q;

    assert_start_begins_R3: assert property (@(posedge clk) disable iff (rst)
        accept |=> (valid_q && beat_q == '0));

    assert_midburst_steady_R10: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !final_beat) |=> (valid_q && beat_q == $past(beat_q) + COL_W'(1)
                                      && anchor_q == $past(anchor_q)));

    assert_end_drops_R8: assert property (@(posedge clk) disable iff (rst)
        (final_beat && !start_i) |=> !valid_q);

    assert_beat_in_span_R2: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> ((beat_q & ~mask_q) == '0));
endmodule

// File: rtl/burst_col_order.sv
module burst_col_order
    import burst_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [COL_W-1:0] anchor_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic [COL_W-1:0] beat_i,
    input  order_e           order_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] low_start;
    logic [COL_W-1:0] offset;

    always_comb begin
        low_start = anchor_i & mask_i;
        if (order_i == ORD_ILV)
            offset = low_start ^ beat_i;
        else
            offset = low_start + beat_i;
        col_o = (anchor_i & ~mask_i) | (offset & mask_i);
    end

    // Columns never leave the aligned block of the start column (R4, R5).
    assert_stays_in_block_R4: assert property (@(posedge clk) disable iff (rst)
        valid_i |-> ((col_o & ~mask_i) == (anchor_i & ~mask_i)));
endmodule

// File: rtl/sdram_burst_addr_gen.sv
module sdram_burst_addr_gen
    import burst_pkg::*;
#(
    parameter int unsigned COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             order_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);
    burst_mode_t      mode_w;
    logic [COL_W-1:0] req_mask;
    logic [COL_W-1:0] beat_w;
    logic [COL_W-1:0] anchor_w;
    logic [COL_W-1:0] live_mask;
    order_e           live_order;

    burst_mode_decode u_decode (
        .len_code_i (len_code_i),
        .order_i    (order_i),
        .mode_o     (mode_w)
    );

    burst_span_mask #(.COL_W(COL_W)) u_mask (
        .span_i (mode_w.span),
        .mask_o (req_mask)
    );

    burst_beat_seq #(.COL_W(COL_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .term_i      (term_i),
        .start_col_i (start_col_i),
        .mode_i      (mode_w),
        .mask_i      (req_mask),
        .valid_o     (valid_o),
        .last_o      (last_o),
        .beat_o      (beat_w),
        .anchor_o    (anchor_w),
        .mask_o      (live_mask),
        .order_o     (live_order)
    );

    burst_col_order #(.COL_W(COL_W)) u_order (
        .clk      (clk),
        .rst      (rst),
        .valid_i  (valid_o),
        .anchor_i (anchor_w),
        .mask_i   (live_mask),
        .beat_i   (beat_w),
        .order_i  (live_order),
        .col_o    (col_o)
    );

    assert_last_with_valid_R8: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

    assert_term_ends_R9: assert property (@(posedge clk) disable iff (rst)
        (valid_o && term_i) |-> last_o);

    assert_seq_step_R4: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && live_order == ORD_SEQ) |=>
        ((col_o & live_mask) == (($past(col_o) + COL_W'(1)) & live_mask)));

    assert_back_to_back_R10: assert property (@(posedge clk) disable iff (rst)
        (last_o && start_i) |=> (valid_o && col_o == $past(start_col_i)));
endmodule

// File: tb/test_sdram_burst_addr_gen.sv
`timescale 1ns/1ps
module test_sdram_burst_addr_gen;
    localparam int COL_W = 10;
    localparam int PAGE  = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst;
    logic             start_i;
    logic [COL_W-1:0] start_col_i;
    logic [2:0]       len_code_i;
    logic             order_i;
    logic             term_i;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;

    int n_cmp = 0;
    int n_bad = 0;

    sdram_burst_addr_gen #(.COL_W(COL_W)) i_sdram_burst_addr_gen (
        .clk (clk), .rst (rst), .start_i (start_i), .start_col_i (start_col_i),
        .len_code_i (len_code_i), .order_i (order_i), .term_i (term_i),
        .col_o (col_o), .valid_o (valid_o), .last_o (last_o)
    );

    always #2 clk = ~clk;

    function automatic int exp_len(input logic [2:0] c);
        case (c)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return PAGE;
            default: return 1;
        endcase
    endfunction

    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
            input logic [2:0] c, input logic t, input int i);
        int len, lo, base;
        len = exp_len(c);
        if (len == PAGE) return COL_W'((int'(s) + i) % PAGE);
        lo   = int'(s) % len;
        base = int'(s) - lo;
        if (t) return COL_W'(base + (lo ^ i));
        return COL_W'(base + ((lo + i) % len));
    endfunction

    task automatic check(input string req, input logic ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Plays one burst whose start is already driven; checks every beat.
    task automatic play(input logic [COL_W-1:0] s, input logic [2:0] c, input logic t,
                        input int term_at, input bit poke, input bit chain,
                        input logic [COL_W-1:0] ns, input logic [2:0] nc, input logic nt);
        int len;
        logic [COL_W-1:0] e;
        bit is_last;
        len = exp_len(c);
        @(negedge clk);
        start_i = 1'b0;
        term_i  = 1'b0;
        for (int i = 0; i < len; i++) begin
            term_i = (i == term_at);
            #1;
            e       = exp_col(s, c, t, i);
            is_last = (i == len - 1) || (i == term_at);
            // R3 beat 0 equals start column; R4/R5/R6/R7 ordering; R2 span
            check(len == PAGE ? "R7" : (t ? "R5" : "R4"), valid_o && col_o == e,
                  "beat column", {valid_o, 21'd0, col_o}, {1'b1, 21'd0, e});
            // R8 last on final beat; R9 last on terminate
            check(i == term_at ? "R9" : "R8", last_o == is_last, "last flag",
                  32'(last_o), 32'(is_last));
            if (is_last) begin
                if (chain) begin
                    start_i = 1'b1; start_col_i = ns; len_code_i = nc; order_i = nt;
                end
                break;
            end
            if (poke && i == 0) begin
                // R10 stray start mid-burst must be ignored
                start_i = 1'b1; start_col_i = COL_W'($urandom);
                len_code_i = 3'($urandom); order_i = 1'($urandom);
            end
            @(negedge clk);
            start_i = 1'b0;
            term_i  = 1'b0;
        end
        if (!chain) begin
            @(negedge clk);
            start_i = 1'b0;
            term_i  = 1'b1;
            #1;
            // R8 burst over; R9 idle terminate changes nothing
            check("R8", valid_o == 1'b0, "valid after last", 32'(valid_o), 32'd0);
            check("R9", last_o == 1'b0, "idle terminate", 32'(last_o), 32'd0);
            term_i = 1'b0;
        end
    endtask

    task automatic issue(input logic [COL_W-1:0] s, input logic [2:0] c, input logic t);
        @(negedge clk);
        start_i = 1'b1; start_col_i = s; len_code_i = c; order_i = t;
    endtask

    function automatic logic [2:0] rand_code();
        int r;
        r = int'($urandom_range(0, 19));
        if (r < 4) return 3'd0;
        if (r < 8) return 3'd1;
        if (r < 12) return 3'd2;
        if (r < 16) return 3'd3;
        if (r < 18) return 3'd7;
        return 3'(4 + $urandom_range(0, 2));
    endfunction

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [COL_W-1:0] s, ns;
        logic [2:0] c, nc;
        logic t, nt;
        int len, ta;
        bit poke, chain;
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; start_i = 1'b0; start_col_i = '0; len_code_i = '0;
        order_i = 1'b0; term_i = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R1", valid_o == 1'b0 && last_o == 1'b0, "reset outputs",
              {valid_o, last_o}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // Directed: seq and interleaved of length 8 from offset 5
        issue(10'h0AD, 3'd3, 1'b0); play(10'h0AD, 3'd3, 1'b0, -1, 0, 0, '0, '0, 0);
        issue(10'h0AD, 3'd3, 1'b1); play(10'h0AD, 3'd3, 1'b1, -1, 0, 0, '0, '0, 0);
        // R2 reserved code is one beat
        issue(10'h3FF, 3'd5, 1'b1); play(10'h3FF, 3'd5, 1'b1, -1, 0, 0, '0, '0, 0);
        // R6 page with interleaved request stays sequential; R7 wraps at page end
        issue(10'h3FC, 3'd7, 1'b1); play(10'h3FC, 3'd7, 1'b0, 9, 1, 0, '0, '0, 0);
        // R7 whole page without terminate
        issue(10'h123, 3'd7, 1'b0); play(10'h123, 3'd7, 1'b0, -1, 0, 0, '0, '0, 0);
        // R9 terminate on beat 0 of a page burst
        issue(10'h010, 3'd7, 1'b0); play(10'h010, 3'd7, 1'b0, 0, 0, 0, '0, '0, 0);
        // R10 back-to-back chain: 4-beat into 2-beat interleaved
        issue(10'h006, 3'd2, 1'b0); play(10'h006, 3'd2, 1'b0, -1, 1, 1, 10'h201, 3'd1, 1'b1);
        play(10'h201, 3'd1, 1'b1, -1, 0, 0, '0, '0, 0);

        // Random mix
        s = COL_W'($urandom); c = rand_code(); t = 1'($urandom);
        issue(s, c, t);
        for (int k = 0; k < 400; k++) begin
            len = exp_len(c);
            ta  = ($urandom_range(0, 9) < 3) ? int'($urandom_range(0, len > 16 ? 16 : len - 1)) : -1;
            if (len == PAGE && ta < 0 && $urandom_range(0, 9) != 0) ta = int'($urandom_range(0, 40));
            poke  = (len > 1) && (ta != 0) && ($urandom_range(0, 9) < 3);
            chain = ($urandom_range(0, 9) < 4);
            ns = COL_W'($urandom); nc = rand_code(); nt = 1'($urandom);
            play(s, c, (len == PAGE) ? 1'b0 : t, ta, poke, chain, ns, nc, nt);
            if (!chain) issue(ns, nc, nt);
            s = ns; c = nc; t = nt;
        end
        play(s, c, (exp_len(c) == PAGE) ? 1'b0 : t, -1, 0, 0, '0, '0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule